// File: doc/BRIEF.md
# Parallel Display Bus Transfer Engine

This block moves data between an on-chip producer and an external display controller over a narrow parallel bus. Words of 32 bits enter a write FIFO and are broken into bus picks of programmable width, by default 8 or 16 bits, with the least-significant pick sent first. For every pick the engine drives a write or read strobe whose low phase and total cycle length are programmed in ticks. A tick is the functional clock divided by an integer from 1 to 8, and reads and writes each have their own pair of timing fields. Chip-select and the command/data line follow their control inputs.

A transfer starts with a one-cycle `start` pulse and runs for a programmed number of bus cycles. A write transfer waits, with the strobe held high, whenever the write FIFO runs dry, and picks up again as soon as a word arrives. A read transfer samples the bus on the last low tick of each read strobe, packs the picks into 32-bit words in the same order, and pushes them into a read FIFO. If the selected cycle field would give fewer than three ticks, the block resets itself instead of starting. A small identification sequencer returns a fixed pattern after it is cleared.

Top module: `pbus_xfer_engine`

## Requirements
- R1: The tick is `clk` divided by `cfg_clk_div`+1. Every bus strobe edge falls on a tick, so all strobe timing is a multiple of that many clocks.
- R2: In a write transfer, `bus_we_n` stays low for min(`cfg_wr_low`+1, `cfg_wr_cyc`) ticks of each bus cycle. Consecutive strobe falls are `cfg_wr_cyc`+1 ticks apart.
- R3: In a read transfer, `bus_re_n` uses `cfg_rd_low`/`cfg_rd_cyc` in the same way. `bus_din` is sampled on the last low tick, and `bus_we_n` and `bus_re_n` are never low together.
- R4: A pick is `cfg_pick_w`+1 bits wide, and `cfg_pick_n`+1 picks make up one word. The picks leave least-significant first on `bus_dout`, with the bits above the pick width driven to zero.
- R5: A transfer runs exactly `cfg_len`+1 bus cycles and then drops `busy`. `wr_done` is 0 while a write transfer is in progress and 1 otherwise.
- R6: During a write transfer, when a new word is needed and the write FIFO is empty, the strobe stays high and `busy` stays 1. The transfer resumes once a word is pushed.
- R7: If `start` is pulsed while the selected cycle field is below 2, the block does not start. Instead it resets itself: both FIFOs are emptied and `busy` stays 0.
- R8: `bus_cs_n` follows `cfg_cs_ctl` and `bus_dc` follows `cfg_data_sel` (0 = command, 1 = data) one clock later. When `cfg_we_ctl` is 1, a write transfer runs with no strobe pulses.
- R9: Read picks are packed least-significant first into words that go into the read FIFO. A word left partial at the end of a transfer is pushed with its unfilled bits set to zero.
- R10: After `id_clear`, `id_data` shows 0x55555555. Each following `id_read` steps to 0xAAAAAAAA, then the component code, then the version word (major in bits 31:16, minor in bits 15:0). The version word repeats after that.
- R11: While `cfg_enable` is 0, `start` is ignored. While `cfg_soft_reset` is 1, the engine is idled and both FIFOs are emptied.
- R12: The write FIFO holds 8 words and raises `wf_full` when it is full. A push while full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Block enable |
| cfg_soft_reset | input | 1 | Soft reset of the engine and FIFOs |
| cfg_clk_div | input | 3 | Tick divider minus one |
| cfg_wr_low | input | 4 | Write strobe low ticks minus one |
| cfg_wr_cyc | input | 6 | Write cycle ticks minus one |
| cfg_rd_low | input | 4 | Read strobe low ticks minus one |
| cfg_rd_cyc | input | 6 | Read cycle ticks minus one |
| cfg_pick_w | input | 5 | Pick width minus one |
| cfg_pick_n | input | 5 | Picks per word minus one |
| cfg_len | input | 18 | Bus cycles minus one |
| cfg_read | input | 1 | Direction: 1 = read transfer |
| cfg_data_sel | input | 1 | 0 = command, 1 = data |
| cfg_cs_ctl | input | 1 | Chip-select control, 0 asserts |
| cfg_we_ctl | input | 1 | Write strobe gate, 0 allows pulses |
| start | input | 1 | Start pulse |
| busy | output | 1 | Transfer in progress |
| wr_done | output | 1 | All write cycles finished |
| wf_push | input | 1 | Write FIFO push |
| wf_data | input | 32 | Write FIFO data |
| wf_full | output | 1 | Write FIFO full |
| wf_empty | output | 1 | Write FIFO empty |
| rf_pop | input | 1 | Read FIFO pop |
| rf_data | output | 32 | Read FIFO head word |
| rf_empty | output | 1 | Read FIFO empty |
| bus_cs_n | output | 1 | Chip-select, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_re_n | output | 1 | Read strobe, active low |
| bus_dc | output | 1 | Command/data select |
| bus_dout | output | 16 | Bus write data |
| bus_din | input | 16 | Bus read data |
| id_clear | input | 1 | Restart the ID sequence |
| id_read | input | 1 | Advance the ID sequence |
| id_data | output | 32 | ID word |

## Verification
Some properties are checked on every clock by the assertions. The two strobes are never low at the same time. Strobe edges happen only right after a divider tick. The FIFO occupancy never goes past its depth, and no pop is issued on an empty write FIFO. Chip-select and the command/data line track their controls. A self-reset start leaves the engine idle with an empty FIFO. Some behaviour can only be shown by the bench scenarios. These are the exact low-phase and period lengths across several divider and timing settings, pick order and masking, stall and resume on an empty FIFO, packing of partial read words, and the identification sequence.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int WORD_W = 32;
  localparam int LOW_W  = 4;
  localparam int CYC_W  = 6;
  localparam int PICK_W = 5;

  typedef struct packed {
    logic [LOW_W-1:0] low_m1;
    logic [CYC_W-1:0] cyc_m1;
  } strobe_tim_t;

  function automatic logic [CYC_W-1:0] low_ticks_eff(strobe_tim_t t);
    logic [CYC_W-1:0] lt;
    lt = CYC_W'(t.low_m1) + CYC_W'(1);
    return (lt <= t.cyc_m1) ? lt : t.cyc_m1;
  endfunction
endpackage

// File: rtl/pbus_fifo.sv
module pbus_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (int'(wr_ptr) == DEPTH-1) ? '0 : wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= (int'(rd_ptr) == DEPTH-1) ? '0 : rd_ptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R12: occupancy never exceeds the depth
  p_count_bound_r12: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R12: a full FIFO given a lone push keeps its count
  p_full_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> full);
endmodule

// File: rtl/pbus_tick_div.sv
module pbus_tick_div #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div_m1,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt >= div_m1);

  always_ff @(posedge clk) begin
    if (rst || !en)  cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + DIV_W'(1);
  end

  // R1: with a divider above one, ticks are never back to back
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (rst)
    (tick && div_m1 != '0) |=> (!tick || div_m1 == '0));
endmodule

// File: rtl/pbus_id_seq.sv
module pbus_id_seq #(
  parameter logic [31:0] COMP_CODE = 32'h00C0_FFEE,
  parameter logic [15:0] VER_MAJ   = 16'd2,
  parameter logic [15:0] VER_MIN   = 16'd1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        rd,
  output logic [31:0] data
);
  logic [1:0] idx;

  always_ff @(posedge clk) begin
    if (rst)                     idx <= 2'd3;
    else if (clear)              idx <= 2'd0;
    else if (rd && idx != 2'd3)  idx <= idx + 2'd1;
  end

  always_comb begin
    case (idx)
      2'd0:    data = 32'h5555_5555;
      2'd1:    data = 32'hAAAA_AAAA;
      2'd2:    data = COMP_CODE;
      default: data = {VER_MAJ, VER_MIN};
    endcase
  end

  // R10: a clear always leads to the first sync pattern
  p_id_first_r10: assert property (@(posedge clk) disable iff (rst)
    clear |=> (data == 32'h5555_5555));
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter int LEN_W = 18,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH) + 1,
  localparam int SH_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start,
  input  logic              dir_rd_in,
  input  strobe_tim_t       tim_in,
  input  logic [PICK_W-1:0] pw_m1,
  input  logic [PICK_W-1:0] pc_m1,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              we_block,
  input  logic              wf_empty,
  input  logic [WORD_W-1:0] wf_rdata,
  input  logic [CW-1:0]     rf_count,
  input  logic [BUS_W-1:0]  bus_din,
  output logic              wf_pop,
  output logic              rf_push,
  output logic [WORD_W-1:0] rf_wdata,
  output logic              we_n,
  output logic              re_n,
  output logic [BUS_W-1:0]  dout,
  output logic              busy,
  output logic              dir_rd
);
  logic              active, in_cyc;
  logic [CYC_W-1:0]  phase, cyc_q, low_q;
  logic [PICK_W-1:0] pick, pw_q, pc_q;
  logic [LEN_W-1:0]  left;
  logic [WORD_W-1:0] word_q;

  logic              cyc_end, slot_free, last_cyc, more, word_last, push_now;
  logic              need_word, room, can_begin, capture;
  logic [PICK_W-1:0] next_pick;
  logic [CYC_W-1:0]  width;
  logic [SH_W-1:0]   out_sh, cap_sh;
  logic [BUS_W-1:0]  mask, pick_val;
  logic [WORD_W-1:0] src_word, shifted, cap_word;

  assign busy   = active;
  assign dir_rd = dir_rd_in & 1'b0 | rd_q_w;

  logic rd_q_w;

  always_comb begin
    cyc_end   = tick && in_cyc && (phase == cyc_q);
    slot_free = !in_cyc || cyc_end;
    last_cyc  = (left == '0);
    more      = !in_cyc || !last_cyc;
    word_last = (pick == pc_q);
    push_now  = rd_q_w && cyc_end && (word_last || last_cyc);
    if (in_cyc) next_pick = word_last ? '0 : pick + PICK_W'(1);
    else        next_pick = pick;
    need_word = (next_pick == '0);
    if (rd_q_w) room = (int'(rf_count) + (push_now ? 1 : 0)) < DEPTH;
    else        room = !wf_empty;
    can_begin = active && tick && slot_free && more && (!need_word || room);
    wf_pop    = can_begin && !rd_q_w && need_word;
    capture   = rd_q_w && in_cyc && tick && (phase == low_q - CYC_W'(1));

    width  = CYC_W'(pw_q) + CYC_W'(1);
    if (int'(width) >= BUS_W) mask = '1;
    else                      mask = (BUS_W'(1) << width) - BUS_W'(1);

    src_word = (need_word && !rd_q_w) ? wf_rdata : word_q;
    out_sh   = SH_W'(next_pick) * SH_W'(width);
    shifted  = src_word >> out_sh;
    pick_val = shifted[BUS_W-1:0] & mask;

    cap_sh   = SH_W'(pick) * SH_W'(width);
    cap_word = word_q | (WORD_W'(bus_din & mask) << cap_sh);

    rf_push  = push_now;
    rf_wdata = word_q;
  end

  logic rd_q, gate_q;
  assign rd_q_w = rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      in_cyc <= 1'b0;
      phase  <= '0;
      cyc_q  <= '0;
      low_q  <= '0;
      pick   <= '0;
      pw_q   <= '0;
      pc_q   <= '0;
      left   <= '0;
      word_q <= '0;
      rd_q   <= 1'b0;
      gate_q <= 1'b0;
      we_n   <= 1'b1;
      re_n   <= 1'b1;
      dout   <= '0;
    end else if (start && !active) begin
      active <= 1'b1;
      in_cyc <= 1'b0;
      phase  <= '0;
      pick   <= '0;
      rd_q   <= dir_rd_in;
      cyc_q  <= tim_in.cyc_m1;
      low_q  <= low_ticks_eff(tim_in);
      pw_q   <= pw_m1;
      pc_q   <= pc_m1;
      left   <= len_m1;
      word_q <= '0;
    end else if (active && tick) begin
      if (capture) word_q <= cap_word;
      if (can_begin) begin
        in_cyc <= 1'b1;
        phase  <= '0;
        pick   <= next_pick;
        if (need_word) word_q <= rd_q ? '0 : wf_rdata;
        if (!rd_q) dout <= pick_val;
        gate_q <= !we_block;
        we_n   <= rd_q || we_block;
        re_n   <= !rd_q;
        if (in_cyc) left <= left - LEN_W'(1);
      end else if (cyc_end) begin
        in_cyc <= 1'b0;
        pick   <= next_pick;
        we_n   <= 1'b1;
        re_n   <= 1'b1;
        if (last_cyc) active <= 1'b0;
        else          left   <= left - LEN_W'(1);
      end else if (in_cyc) begin
        phase <= phase + CYC_W'(1);
        if (phase + CYC_W'(1) == low_q) begin
          we_n <= 1'b1;
          re_n <= 1'b1;
        end
      end
    end
  end

  // R3: the two strobes are never active together
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !re_n));
  // R1: strobes only move on the clock after a tick
  p_edge_on_tick_r1: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(we_n) && $stable(re_n)));
  // R6: a word is never taken from an empty write FIFO
  p_pop_has_data_r6: assert property (@(posedge clk) disable iff (rst)
    wf_pop |-> !wf_empty);
  // R5: an idle engine drives no strobe
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !active |-> (we_n && re_n));
  // R8: a blocked write strobe stays high through the transfer
  p_we_blocked_r8: assert property (@(posedge clk) disable iff (rst)
    (active && !gate_q && !rd_q && in_cyc) |-> we_n);
endmodule

// File: rtl/pbus_xfer_engine.sv
module pbus_xfer_engine
  import pbus_pkg::*;
#(
  parameter int BUS_W      = 16,
  parameter int LEN_W      = 18,
  parameter int DIV_W      = 3,
  parameter int FIFO_DEPTH = 8,
  localparam int CW        = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_enable,
  input  logic              cfg_soft_reset,
  input  logic [DIV_W-1:0]  cfg_clk_div,
  input  logic [LOW_W-1:0]  cfg_wr_low,
  input  logic [CYC_W-1:0]  cfg_wr_cyc,
  input  logic [LOW_W-1:0]  cfg_rd_low,
  input  logic [CYC_W-1:0]  cfg_rd_cyc,
  input  logic [PICK_W-1:0] cfg_pick_w,
  input  logic [PICK_W-1:0] cfg_pick_n,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_read,
  input  logic              cfg_data_sel,
  input  logic              cfg_cs_ctl,
  input  logic              cfg_we_ctl,
  input  logic              start,
  output logic              busy,
  output logic              wr_done,
  input  logic              wf_push,
  input  logic [WORD_W-1:0] wf_data,
  output logic              wf_full,
  output logic              wf_empty,
  input  logic              rf_pop,
  output logic [WORD_W-1:0] rf_data,
  output logic              rf_empty,
  output logic              bus_cs_n,
  output logic              bus_we_n,
  output logic              bus_re_n,
  output logic              bus_dc,
  output logic [BUS_W-1:0]  bus_dout,
  input  logic [BUS_W-1:0]  bus_din,
  input  logic              id_clear,
  input  logic              id_read,
  output logic [WORD_W-1:0] id_data
);
  logic              self_rst_q, int_rst, tick;
  logic              start_req, cyc_bad, eng_start, eng_rd;
  logic              wf_pop, rf_push, rf_full;
  logic [WORD_W-1:0] wf_rdata, rf_wdata;
  logic [CW-1:0]     wf_count, rf_count;
  strobe_tim_t       tim_sel;

  assign int_rst   = rst || cfg_soft_reset || self_rst_q;
  assign tim_sel   = cfg_read ? '{low_m1: cfg_rd_low, cyc_m1: cfg_rd_cyc}
                              : '{low_m1: cfg_wr_low, cyc_m1: cfg_wr_cyc};
  assign start_req = start && cfg_enable && !busy;
  assign cyc_bad   = (tim_sel.cyc_m1 < CYC_W'(2));
  assign eng_start = start_req && !cyc_bad;
  assign wr_done   = !(busy && !eng_rd);

  always_ff @(posedge clk) begin
    if (rst) begin
      self_rst_q <= 1'b0;
      bus_cs_n   <= 1'b1;
      bus_dc     <= 1'b0;
    end else begin
      self_rst_q <= start_req && cyc_bad;
      bus_cs_n   <= cfg_cs_ctl;
      bus_dc     <= cfg_data_sel;
    end
  end

  pbus_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(int_rst), .en(cfg_enable), .div_m1(cfg_clk_div), .tick(tick)
  );

  pbus_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_wfifo (
    .clk(clk), .rst(int_rst), .push(wf_push), .din(wf_data), .pop(wf_pop),
    .dout(wf_rdata), .full(wf_full), .empty(wf_empty), .count(wf_count)
  );

  pbus_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rfifo (
    .clk(clk), .rst(int_rst), .push(rf_push), .din(rf_wdata), .pop(rf_pop),
    .dout(rf_data), .full(rf_full), .empty(rf_empty), .count(rf_count)
  );

  pbus_seq #(.BUS_W(BUS_W), .LEN_W(LEN_W), .DEPTH(FIFO_DEPTH)) u_seq (
    .clk(clk), .rst(int_rst), .tick(tick), .start(eng_start),
    .dir_rd_in(cfg_read), .tim_in(tim_sel), .pw_m1(cfg_pick_w),
    .pc_m1(cfg_pick_n), .len_m1(cfg_len), .we_block(cfg_we_ctl),
    .wf_empty(wf_empty), .wf_rdata(wf_rdata), .rf_count(rf_count),
    .bus_din(bus_din), .wf_pop(wf_pop), .rf_push(rf_push),
    .rf_wdata(rf_wdata), .we_n(bus_we_n), .re_n(bus_re_n),
    .dout(bus_dout), .busy(busy), .dir_rd(eng_rd)
  );

  pbus_id_seq u_id (
    .clk(clk), .rst(rst), .clear(id_clear), .rd(id_read), .data(id_data)
  );

  // R8: chip-select and command/data track their controls one clock later
  p_cs_follow_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (bus_cs_n == $past(cfg_cs_ctl) && bus_dc == $past(cfg_data_sel)));
  // R7: a start with a too-short cycle leaves the block idle and flushed
  p_self_reset_r7: assert property (@(posedge clk) disable iff (rst || cfg_soft_reset)
    (start_req && cyc_bad) |=> ##1 (wf_empty && !busy));
  // R11: a disabled block never begins a transfer
  p_disabled_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (!cfg_enable && !busy) |=> !busy);
  // R12: the read FIFO is never pushed when full
  p_rf_no_overflow_r12: assert property (@(posedge clk) disable iff (rst)
    !(rf_push && rf_full));
endmodule

// File: tb/pbus_xfer_engine_bench.sv
module pbus_xfer_engine_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_enable = 1'b1, cfg_soft_reset = 1'b0;
  logic [2:0]  cfg_clk_div = '0;
  logic [3:0]  cfg_wr_low = 4'd1, cfg_rd_low = 4'd1;
  logic [5:0]  cfg_wr_cyc = 6'd3, cfg_rd_cyc = 6'd3;
  logic [4:0]  cfg_pick_w = 5'd15, cfg_pick_n = 5'd1;
  logic [17:0] cfg_len = '0;
  logic        cfg_read = 1'b0, cfg_data_sel = 1'b1, cfg_cs_ctl = 1'b1, cfg_we_ctl = 1'b0;
  logic        start = 1'b0;
  logic        busy, wr_done;
  logic        wf_push = 1'b0;
  logic [31:0] wf_data = '0;
  logic        wf_full, wf_empty;
  logic        rf_pop = 1'b0;
  logic [31:0] rf_data;
  logic        rf_empty;
  logic        bus_cs_n, bus_we_n, bus_re_n, bus_dc;
  logic [15:0] bus_dout;
  logic [15:0] bus_din = '0;
  logic        id_clear = 1'b0, id_read = 1'b0;
  logic [31:0] id_data;

  int checks = 0, errors = 0;
  int nfalls, low_clk, period, t0;
  logic [15:0] picks [16];

  always #5 clk = ~clk;

  pbus_xfer_engine u_pbus_xfer_engine (.*);

  // div_m1, low_m1, cyc_m1, expected low clocks, expected period clocks
  localparam int NV = 5;
  localparam int VEC [NV][5] = '{
    '{0, 1,  3,  2,  4},
    '{1, 2,  5,  6, 12},
    '{3, 0,  2,  4, 12},
    '{0, 15, 4,  4,  5},
    '{7, 3,  9, 32, 80}
  };

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(logic [31:0] w);
    @(negedge clk); wf_push = 1'b1; wf_data = w;
    @(negedge clk); wf_push = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic monitor(int maxclk, bit rd);
    logic prev, cur;
    int   cnt;
    nfalls = 0; low_clk = 0; period = 0; t0 = 0; cnt = 0;
    prev = 1'b1;
    while (cnt < maxclk && busy) begin
      cur = rd ? bus_re_n : bus_we_n;
      if (prev && !cur) begin
        if (nfalls < 16) picks[nfalls] = bus_dout;
        if (nfalls == 0) t0 = cnt;
        if (nfalls == 1) period = cnt - t0;
        nfalls++;
      end
      if (!cur && nfalls == 1) low_clk++;
      prev = cur;
      cnt++;
      @(negedge clk);
    end
  endtask

  task automatic soft_reset();
    @(negedge clk); cfg_soft_reset = 1'b1;
    @(negedge clk); cfg_soft_reset = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    check(bus_we_n && bus_re_n && bus_cs_n, "R8 reset strobes", {29'd0, bus_we_n, bus_re_n, bus_cs_n}, 32'd7);
    check(!busy && wr_done, "R5 reset idle", {30'd0, busy, wr_done}, 32'd1);
    check(wf_empty && rf_empty, "R12 reset fifos", {30'd0, wf_empty, rf_empty}, 32'd3);
    check(id_data == 32'h0002_0001, "R10 reset id", id_data, 32'h0002_0001);

    // R1 R2 R4: timing table in 16-bit mode, two cycles per vector
    for (int v = 0; v < NV; v++) begin
      cfg_clk_div = 3'(VEC[v][0]); cfg_wr_low = 4'(VEC[v][1]); cfg_wr_cyc = 6'(VEC[v][2]);
      cfg_pick_w = 5'd15; cfg_pick_n = 5'd1; cfg_len = 18'd1; cfg_read = 1'b0;
      push(32'hBEEF_1234);
      pulse_start();
      monitor(5000, 1'b0);
      check(low_clk == VEC[v][3], "R2 low phase", low_clk, VEC[v][3]);
      check(period == VEC[v][4], "R1 period", period, VEC[v][4]);
      check(picks[0] == 16'h1234 && picks[1] == 16'hBEEF, "R4 16-bit order",
            {picks[1], picks[0]}, 32'hBEEF_1234);
    end

    // R4: 8-bit picks, four per word, LSB first
    cfg_clk_div = 3'd0; cfg_wr_low = 4'd0; cfg_wr_cyc = 6'd2;
    cfg_pick_w = 5'd7; cfg_pick_n = 5'd3; cfg_len = 18'd3;
    push(32'h4433_2211);
    pulse_start();
    monitor(2000, 1'b0);
    check(nfalls == 4, "R4 8-bit count", nfalls, 4);
    check({picks[3][7:0], picks[2][7:0], picks[1][7:0], picks[0][7:0]} == 32'h4433_2211,
          "R4 8-bit order", {picks[3][7:0], picks[2][7:0], picks[1][7:0], picks[0][7:0]}, 32'h4433_2211);
    check(picks[3][15:8] == 8'h00, "R4 upper bits zero", {24'd0, picks[3][15:8]}, 32'd0);

    // R5: length of six cycles from three words
    cfg_pick_w = 5'd15; cfg_pick_n = 5'd1; cfg_len = 18'd5;
    push(32'h1); push(32'h2); push(32'h3);
    pulse_start();
    check(!wr_done, "R5 wr_done low while busy", {31'd0, wr_done}, 32'd0);
    monitor(2000, 1'b0);
    check(nfalls == 6, "R5 cycle count", nfalls, 6);
    check(!busy && wr_done && wf_empty, "R5 done", {29'd0, busy, wr_done, wf_empty}, 32'd3);

    // R6: stall on an empty FIFO, resume after a push
    cfg_len = 18'd3;
    push(32'hAAAA_5555);
    pulse_start();
    monitor(100, 1'b0);
    check(nfalls == 2, "R6 picks before stall", nfalls, 2);
    check(busy && bus_we_n && !wr_done, "R6 stalled high", {29'd0, busy, bus_we_n, wr_done}, 32'd6);
    push(32'h6666_7777);
    monitor(2000, 1'b0);
    check(nfalls == 2 && !busy, "R6 resumed", nfalls, 2);
    check(picks[0] == 16'h7777 && picks[1] == 16'h6666, "R6 resumed data", {picks[1], picks[0]}, 32'h6666_7777);

    // R3 R9: read of six 8-bit picks, last word partial
    cfg_read = 1'b1; cfg_rd_low = 4'd1; cfg_rd_cyc = 6'd4;
    cfg_pick_w = 5'd7; cfg_pick_n = 5'd3; cfg_len = 18'd5;
    fork
      begin
        for (int i = 0; i < 6; i++) begin
          @(negedge bus_re_n);
          bus_din = 16'hFFA1 + 16'(i);
        end
      end
    join_none
    pulse_start();
    monitor(2000, 1'b1);
    check(nfalls == 6 && bus_we_n, "R3 read strobes", nfalls, 6);
    check(!rf_empty && rf_data == 32'hA4A3_A2A1, "R9 read word 0", rf_data, 32'hA4A3_A2A1);
    @(negedge clk); rf_pop = 1'b1; @(negedge clk); rf_pop = 1'b0;
    check(rf_data == 32'h0000_A6A5, "R9 partial word", rf_data, 32'h0000_A6A5);
    @(negedge clk); rf_pop = 1'b1; @(negedge clk); rf_pop = 1'b0;
    check(rf_empty, "R9 read fifo drained", {31'd0, rf_empty}, 32'd1);
    cfg_read = 1'b0;

    // R8: chip-select, command/data, write gate
    cfg_cs_ctl = 1'b0; cfg_data_sel = 1'b0;
    repeat (2) @(negedge clk);
    check(!bus_cs_n && !bus_dc, "R8 cs/dc low", {30'd0, bus_cs_n, bus_dc}, 32'd0);
    cfg_data_sel = 1'b1;
    repeat (2) @(negedge clk);
    check(bus_dc, "R8 data select", {31'd0, bus_dc}, 32'd1);
    cfg_we_ctl = 1'b1; cfg_pick_w = 5'd15; cfg_pick_n = 5'd1; cfg_len = 18'd1;
    push(32'h1111_2222);
    pulse_start();
    monitor(2000, 1'b0);
    check(nfalls == 0 && !busy && wf_empty, "R8 gated write", nfalls, 0);
    cfg_we_ctl = 1'b0; cfg_cs_ctl = 1'b1;
    repeat (2) @(negedge clk);
    check(bus_cs_n, "R8 cs released", {31'd0, bus_cs_n}, 32'd1);

    // R7: too-short cycle forces self reset
    cfg_wr_cyc = 6'd1;
    push(32'h5); push(32'h6);
    pulse_start();
    repeat (3) @(negedge clk);
    check(!busy && wf_empty && bus_we_n, "R7 self reset", {29'd0, busy, wf_empty, bus_we_n}, 32'd3);
    cfg_wr_cyc = 6'd3;

    // R11: disabled start ignored, soft reset flushes
    cfg_enable = 1'b0;
    push(32'h9);
    pulse_start();
    repeat (4) @(negedge clk);
    check(!busy && !wf_empty, "R11 start ignored", {30'd0, busy, wf_empty}, 32'd0);
    cfg_enable = 1'b1;
    soft_reset();
    check(wf_empty, "R11 soft reset flush", {31'd0, wf_empty}, 32'd1);

    // R12: nine pushes, only eight kept
    for (int i = 0; i < 9; i++) begin
      push(32'(i));
      if (i == 7) check(wf_full, "R12 full at 8", {31'd0, wf_full}, 32'd1);
    end
    cfg_len = 18'd15;
    pulse_start();
    monitor(5000, 1'b0);
    check(nfalls == 16 && wf_empty && !busy, "R12 ninth dropped", nfalls, 16);

    // R10: identification sequence
    @(negedge clk); id_clear = 1'b1; @(negedge clk); id_clear = 1'b0;
    check(id_data == 32'h5555_5555, "R10 id 0", id_data, 32'h5555_5555);
    @(negedge clk); id_read = 1'b1; @(negedge clk); id_read = 1'b0;
    check(id_data == 32'hAAAA_AAAA, "R10 id 1", id_data, 32'hAAAA_AAAA);
    @(negedge clk); id_read = 1'b1; @(negedge clk); id_read = 1'b0;
    check(id_data == 32'h00C0_FFEE, "R10 id 2", id_data, 32'h00C0_FFEE);
    @(negedge clk); id_read = 1'b1; @(negedge clk); id_read = 1'b0;
    check(id_data == 32'h0002_0001, "R10 id 3", id_data, 32'h0002_0001);
    @(negedge clk); id_read = 1'b1; @(negedge clk); id_read = 1'b0;
    check(id_data == 32'h0002_0001, "R10 id holds", id_data, 32'h0002_0001);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule